// File: doc/BRIEF.md
# Serial Converter Command Bridge

This block connects a simple processor register bus to the internal register file of an analog-to-digital converter over a full-duplex serial link. Software queues 32-bit command words in a command FIFO. The bridge sends each word to the converter, most significant bit first, on a divided serial clock. It receives a 32-bit reply during the same frame and stores that reply in a read FIFO, which software pops through a register.

The converter returns the answer to a command during the frame that follows it. Every command therefore produces exactly one read-FIFO entry. To read a converter register, software sends the read command, then a no-op, pops two words, and keeps only the second one. A write's own reply is a dummy that software discards. Before software can change the configuration, queue a command or clear a status flag, it must write a fixed key to the unlock register.

Bus map (word address on `busAddr`):
- 0: configuration, read/write.
- 1: status, read; write 1 to clear a flag.
- 2: command push, write only.
- 3: read-FIFO pop, read.
- 4: unlock key. A write presents the key. A read returns the unlocked bit in bit 0.

Every other address reads as zero.

Top module: `adc_cmd_bridge`

## Requirements
- R1: A frame lasts exactly 32 serial clock periods and `serSel` is high for the whole frame. `serClk` idles low whenever `serSel` is low. `serOut` carries the command MSB first and changes only while `serClk` falls. `serIn` is sampled on each rising `serClk`.
- R2: Configuration bits [7:4] hold the rate value N. A serial clock period is 4×N input clocks, so a frame is 128×N cycles. N = 0 behaves as N = 1.
- R3: The command FIFO holds 15 words. A push to a full command FIFO is dropped and sets the sticky overflow flag, status bit 2.
- R4: Each completed frame pushes exactly one read-FIFO entry, holding the 32 bits captured from `serIn` with the first bit as the MSB.
- R5: A pop from an empty read FIFO returns zero and sets the sticky underflow flag, status bit 3.
- R6: No frame starts while configuration bit 0 (enable) is clear. Queued commands stay in the command FIFO until enable is set.
- R7: Writes to the configuration, command and status registers are ignored until the key 0x757BDF0D is written to address 4. A wrong key leaves the bridge locked. Reset locks it.
- R8: Status bit 0 latches whenever the command count is below configuration field [11:8]. Status bit 1 latches whenever the read count is nonzero and at least configuration field [15:12]. Writing 1 to a status bit clears it, but the bit sets again while its condition still holds.
- R9: Command fields are opcode [29:26] (0001 read, 0010 write, 0000 no-op), register address [25:16] and data [15:0]. Suppose software sends a read, then a no-op, and pops both replies. The second reply carries the register value in bits [15:0].
- R10: Commands are sent in push order and replies are popped in arrival order. Status bits [11:8] and [19:16] report the command and read FIFO counts.
- R11: No frame starts while the read FIFO holds 15 entries. Commands wait until a pop makes room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe (pops at address 3) |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, combinational |
| serClk | output | 1 | Divided serial clock |
| serSel | output | 1 | High during a frame |
| serOut | output | 1 | Serial command data to converter |
| serIn | input | 1 | Serial reply data from converter |

## Verification
The bench targets the one-command reply lag. A bridge that paired each reply with its own command would return the read value on the first pop instead of the second. Frame lengths are measured at rate values 0, 1 and 3, which would expose an off-by-one divider or a rate of zero taken literally. The bench also fills both FIFOs to catch three faults: a 16th command that is not dropped, frames that overrun a full read FIFO, and a sticky flag that clears while its cause persists. It checks that control writes issued before the key and with enable clear change nothing visible on the bus or on the serial pins.

// File: rtl/adc_bridge_pkg.sv
`timescale 1ns/1ps
package adc_bridge_pkg;
  localparam int WORD_W    = 32;
  localparam int CMD_DEPTH = 15;
  localparam int RD_DEPTH  = 15;
  localparam int CMD_CNT_W = $clog2(CMD_DEPTH + 1);
  localparam int RD_CNT_W  = $clog2(RD_DEPTH + 1);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int RATE_W    = 4;
  localparam int ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG = 3'd0, A_STS = 3'd1, A_CMD = 3'd2, A_POP = 3'd3, A_KEY = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic              cmdPush;
    logic [WORD_W-1:0] cmdWord;
    logic              rdPop;
    logic              enable;
    logic [RATE_W-1:0] rate;
  } ctrl2dp_t;

  typedef struct packed {
    logic [CMD_CNT_W-1:0] cmdCount;
    logic                 cmdFull;
    logic [RD_CNT_W-1:0]  rdCount;
    logic                 rdEmpty;
    logic [WORD_W-1:0]    rdHead;
  } dp2ctrl_t;
endpackage

// File: rtl/adc_bridge_fifo.sv
`timescale 1ns/1ps
module adc_bridge_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 15,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  p_fifo_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/adc_bridge_datapath.sv
`timescale 1ns/1ps
module adc_bridge_datapath
  import adc_bridge_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctrl2dp_t ctl,
  output dp2ctrl_t st,
  output logic     serClk,
  output logic     serSel,
  output logic     serOut,
  input  logic     serIn
);
  localparam int HALF_W = RATE_W + 1;

  logic              busy;
  logic [HALF_W-1:0] halfLim, divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] txShift, rxShift;
  logic [WORD_W-1:0] cmdHead;
  logic              cmdEmpty, cmdPop, rdPush, tick, startFrame;
  logic [RATE_W-1:0] rateEff;

  adc_bridge_fifo #(.WIDTH(WORD_W), .DEPTH(CMD_DEPTH)) u_cmdFifo (
    .clk(clk), .rstN(rstN), .push(ctl.cmdPush), .pushData(ctl.cmdWord),
    .pop(cmdPop), .head(cmdHead), .count(st.cmdCount), .full(st.cmdFull),
    .empty(cmdEmpty));

  adc_bridge_fifo #(.WIDTH(WORD_W), .DEPTH(RD_DEPTH)) u_rdFifo (
    .clk(clk), .rstN(rstN), .push(rdPush), .pushData(rxShift),
    .pop(ctl.rdPop), .head(st.rdHead), .count(st.rdCount), .full(),
    .empty(st.rdEmpty));

  assign rateEff    = (ctl.rate == '0) ? RATE_W'(1) : ctl.rate;
  assign startFrame = !busy && ctl.enable && !cmdEmpty &&
                      (st.rdCount < RD_CNT_W'(RD_DEPTH));
  assign cmdPop     = startFrame;
  assign tick       = busy && (divCnt == halfLim - 1'b1);
  assign rdPush     = tick && serClk && (bitCnt == BIT_W'(WORD_W - 1));
  assign serSel     = busy;
  assign serOut     = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      halfLim <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      serClk  <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else if (startFrame) begin
      busy    <= 1'b1;
      halfLim <= {rateEff, 1'b0};
      divCnt  <= '0;
      bitCnt  <= '0;
      serClk  <= 1'b0;
      txShift <= cmdHead;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        serClk <= !serClk;
        if (!serClk) begin
          rxShift <= {rxShift[WORD_W-2:0], serIn};
        end else begin
          txShift <= {txShift[WORD_W-2:0], 1'b0};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == BIT_W'(WORD_W - 1)) busy <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !serSel |-> !serClk);
  p_out_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (serSel && $past(serSel) && !$fell(serClk)) |-> $stable(serOut));
  p_start_enabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serSel) |-> $past(ctl.enable));
  p_start_room_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serSel) |-> ($past(st.rdCount) < RD_CNT_W'(RD_DEPTH)));
endmodule

// File: rtl/adc_bridge_ctrl.sv
`timescale 1ns/1ps
module adc_bridge_ctrl
  import adc_bridge_pkg::*;
#(
  parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output ctrl2dp_t          ctl,
  input  dp2ctrl_t          st
);
  logic              unlocked;
  logic              enableQ;
  logic [RATE_W-1:0] rateQ, cmdThrQ, dataThrQ;
  logic [3:0]        stsQ, stsSet, stsClr;
  logic              ctrlWr, cfgWr, keyOk;

  assign ctrlWr = busWr && unlocked;
  assign cfgWr  = ctrlWr && (busAddr == A_CFG);
  assign stsClr = (ctrlWr && busAddr == A_STS) ? busWdata[3:0] : 4'b0;
  assign keyOk  = busWr && (busAddr == A_KEY) && (busWdata == UNLOCK_KEY);

  assign ctl.cmdPush = ctrlWr && (busAddr == A_CMD);
  assign ctl.cmdWord = busWdata;
  assign ctl.rdPop   = busRd && (busAddr == A_POP);
  assign ctl.enable  = enableQ;
  assign ctl.rate    = rateQ;

  always_comb begin
    stsSet[0] = ({{(RATE_W+1-CMD_CNT_W){1'b0}}, st.cmdCount} < {1'b0, cmdThrQ});
    stsSet[1] = (st.rdCount != '0) &&
                ({{(RATE_W+1-RD_CNT_W){1'b0}}, st.rdCount} >= {1'b0, dataThrQ});
    stsSet[2] = ctl.cmdPush && st.cmdFull;
    stsSet[3] = ctl.rdPop && st.rdEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      enableQ  <= 1'b0;
      rateQ    <= '0;
      cmdThrQ  <= '0;
      dataThrQ <= '0;
      stsQ     <= '0;
    end else begin
      if (keyOk) unlocked <= 1'b1;
      if (cfgWr) begin
        enableQ  <= busWdata[0];
        rateQ    <= busWdata[7:4];
        cmdThrQ  <= busWdata[11:8];
        dataThrQ <= busWdata[15:12];
      end
      stsQ <= (stsQ & ~stsClr) | stsSet;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CFG: busRdata = {16'b0, dataThrQ, cmdThrQ, rateQ, 3'b0, enableQ};
      A_STS: busRdata = {12'b0, 4'(st.rdCount), 4'b0, 4'(st.cmdCount), 4'b0, stsQ};
      A_POP: busRdata = st.rdEmpty ? '0 : st.rdHead;
      A_KEY: busRdata = {31'b0, unlocked};
      default: busRdata = '0;
    endcase
  end

  p_locked_cfg_r7: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> ($stable(enableQ) && $stable(rateQ) && $stable(cmdThrQ) && $stable(dataThrQ)));
  p_locked_no_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !ctl.cmdPush);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cmdPush && st.cmdFull) |=> stsQ[2]);
  p_sticky_under_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stsQ[3] && !stsClr[3]) |=> stsQ[3]);
  p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdPop && st.rdEmpty) |-> (busRdata == '0));
endmodule

// File: rtl/adc_cmd_bridge.sv
`timescale 1ns/1ps
module adc_cmd_bridge
  import adc_bridge_pkg::*;
#(
  parameter logic [31:0] UNLOCK_KEY = 32'h757B_DF0D
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        serClk,
  output logic        serSel,
  output logic        serOut,
  input  logic        serIn
);
  ctrl2dp_t ctl;
  dp2ctrl_t st;

  adc_bridge_ctrl #(.UNLOCK_KEY(UNLOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ctl(ctl), .st(st));

  adc_bridge_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .st(st), .serClk(serClk),
    .serSel(serSel), .serOut(serOut), .serIn(serIn));
endmodule

// File: tb/adc_cmd_bridge_bench.sv
`timescale 1ns/1ps
module adc_cmd_bridge_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic serClk, serSel, serOut, serIn;

  adc_cmd_bridge u_adc_cmd_bridge (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .serClk(serClk), .serSel(serSel),
    .serOut(serOut), .serIn(serIn));

  always #4 clk = !clk;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  // ---------------- converter model ----------------
  logic [15:0] regFile [1024];
  logic [31:0] pending = '0, replyCur = '0, rxCmd = '0;
  int idx = 0;
  logic [31:0] seenCmd [64];
  int seenN = 0;
  assign serIn = (serSel && idx < 32) ? replyCur[31 - idx] : 1'b0;
  always @(posedge serSel) begin idx = 0; replyCur = pending; end
  always @(negedge serClk) if (serSel) idx = idx + 1;
  always @(posedge serClk) rxCmd = {rxCmd[30:0], serOut};
  always @(negedge serSel) begin
    if (seenN < 64) seenCmd[seenN] = rxCmd;
    seenN = seenN + 1;
    case (rxCmd[29:26])
      4'b0001: pending = {16'h0, regFile[rxCmd[25:16]]};
      4'b0010: begin regFile[rxCmd[25:16]] = rxCmd[15:0]; pending = '0; end
      default: pending = '0;
    endcase
  end

  int selCount = 0;
  always @(negedge clk) if (serSel) selCount = selCount + 1;

  // ---------------- bench reference ----------------
  logic [15:0] shadow [1024];
  logic [31:0] lastCmd = '0;
  logic [31:0] expQ [256];
  int expW = 0, expR = 0;
  logic [31:0] sentQ [256];
  int sentN = 0;

  function automatic logic [31:0] expReply(input logic [31:0] prev);
    return (prev[29:26] == 4'b0001) ? {16'h0, shadow[prev[25:16]]} : 32'h0;
  endfunction

  function automatic logic [31:0] mkCmd(input logic [3:0] op, input logic [9:0] a,
                                        input logic [15:0] d);
    return {2'b00, op, a, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busW(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busR(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a; #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic sendCmd(input logic [31:0] w, input bit accepted);
    busW(3'd2, w);
    if (accepted) begin
      expQ[expW % 256] = expReply(lastCmd);
      expW++;
      sentQ[sentN % 256] = w; sentN++;
      if (w[29:26] == 4'b0010) shadow[w[25:16]] = w[15:0];
      lastCmd = w;
    end
  endtask

  task automatic popCheck(input string req);
    logic [31:0] d;
    busR(3'd3, d);
    check(d == expQ[expR % 256], req, d, expQ[expR % 256]);
    expR++;
  endtask

  task automatic waitDrain();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      busR(3'd1, s);
      if (s[11:8] == 4'd0 && !serSel) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s;
    int base, seen0;
    for (int i = 0; i < 1024; i++) begin regFile[i] = '0; shadow[i] = '0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    busR(3'd1, d); check(d == 32'h0, "R8 reset status", d, 32'h0);
    busR(3'd0, d); check(d == 32'h0, "R7 reset cfg", d, 32'h0);
    busR(3'd4, d); check(d == 32'h0, "R7 reset locked", d, 32'h0);
    check(serSel == 1'b0 && serClk == 1'b0, "R1 reset idle", {serSel, serClk}, 32'h0);

    // R7 lock behaviour
    busW(3'd0, 32'h0000_FF11);
    busW(3'd2, 32'h0800_0001);
    busR(3'd0, d); check(d == 32'h0, "R7 cfg ignored while locked", d, 32'h0);
    busR(3'd1, d); check(d[11:8] == 4'd0, "R7 cmd ignored while locked", d[11:8], 32'h0);
    busW(3'd4, 32'h1234_5678);
    busR(3'd4, d); check(d == 32'h0, "R7 wrong key stays locked", d, 32'h0);
    busW(3'd4, 32'h757B_DF0D);
    busR(3'd4, d); check(d == 32'h1, "R7 key unlocks", d, 32'h1);

    // R2 frame lengths
    busW(3'd0, 32'h0000_0011);
    busR(3'd0, d); check(d == 32'h11, "R7 cfg writable", d, 32'h11);
    base = selCount; sendCmd(32'h0, 1); waitDrain();
    check(selCount - base == 128, "R2 rate1 frame", selCount - base, 128);
    popCheck("R4 reply rate1");
    busW(3'd0, 32'h0000_0001);
    base = selCount; sendCmd(32'h0, 1); waitDrain();
    check(selCount - base == 128, "R2 rate0 as rate1", selCount - base, 128);
    popCheck("R4 reply rate0");
    busW(3'd0, 32'h0000_0031);
    base = selCount; sendCmd(32'h0, 1); waitDrain();
    check(selCount - base == 384, "R2 rate3 frame", selCount - base, 384);
    popCheck("R4 reply rate3");

    // R1 / R9 read transaction
    busW(3'd0, 32'h0000_0011);
    seen0 = seenN;
    sendCmd(mkCmd(4'b0010, 10'h12, 16'hBEEF), 1);
    sendCmd(mkCmd(4'b0001, 10'h12, 16'h0), 1);
    sendCmd(32'h0, 1);
    waitDrain();
    check(seenCmd[seen0] == 32'h0812_BEEF, "R1 MSB-first command bits", seenCmd[seen0], 32'h0812_BEEF);
    check(seenN - seen0 == 3, "R4 one frame per command", seenN - seen0, 3);
    popCheck("R9 write dummy");
    popCheck("R9 read reply lag");
    busR(3'd3, d); expR++;
    check(d == 32'h0000_BEEF, "R9 second pop holds data", d, 32'h0000_BEEF);

    // R6 enable off
    busW(3'd0, 32'h0000_0010);
    base = selCount;
    sendCmd(mkCmd(4'b0010, 10'h3, 16'h00A5), 1);
    sendCmd(mkCmd(4'b0001, 10'h3, 16'h0), 1);
    sendCmd(32'h0, 1);
    repeat (600) @(negedge clk);
    check(selCount == base, "R6 no frame while disabled", selCount - base, 0);
    busR(3'd1, d); check(d[11:8] == 4'd3, "R6 commands held", d[11:8], 3);

    // R8 status latching (cmdThr=4, dataThr=2, still disabled)
    busW(3'd0, 32'h0000_2410);
    repeat (2) @(negedge clk);
    busR(3'd1, d); check(d[0] == 1'b1, "R8 cmd below threshold latched", d[3:0], 1);
    busW(3'd0, 32'h0000_2210);
    busW(3'd1, 32'h1);
    busR(3'd1, d); check(d[0] == 1'b0, "R8 w1c clears", d[3:0], 0);
    busW(3'd0, 32'h0000_2211);
    waitDrain();
    busW(3'd1, 32'h3);
    busR(3'd1, d); check(d[1:0] == 2'b11, "R8 bits reset while condition holds", d[3:0], 3);
    popCheck("R10 order a"); popCheck("R10 order b"); popCheck("R10 order c");
    busW(3'd1, 32'h2);
    busR(3'd1, d); check(d[1] == 1'b0, "R8 data bit clears after pops", d[3:0], 0);

    // R3 / R11 fill
    busW(3'd0, 32'h0000_0000);
    for (int i = 0; i < 15; i++) sendCmd(mkCmd(4'b0010, 10'(i + 32), 16'(i)), 1);
    sendCmd(mkCmd(4'b0010, 10'h3FF, 16'hDEAD), 0);
    busR(3'd1, d);
    check(d[11:8] == 4'd15, "R3 depth 15", d[11:8], 15);
    check(d[2] == 1'b1, "R3 overflow flag", d[3:0], 4);
    seen0 = seenN;
    busW(3'd0, 32'h0000_0001);
    waitDrain();
    busR(3'd1, d); check(d[19:16] == 4'd15, "R11 read fifo full", d[19:16], 15);
    sendCmd(32'h0, 1); sendCmd(32'h0, 1);
    repeat (600) @(negedge clk);
    busR(3'd1, d); check(d[11:8] == 4'd2 && d[2], "R11 held while full, R3 sticky", d, 32'h0);
    popCheck("R11 pop makes room");
    repeat (300) @(negedge clk);
    busR(3'd1, d); check(d[11:8] == 4'd1, "R11 one frame after pop", d[11:8], 1);
    check(seenCmd[seen0 + 14] == mkCmd(4'b0010, 10'd46, 16'd14), "R10 push order", seenCmd[seen0 + 14], mkCmd(4'b0010, 10'd46, 16'd14));
    for (int i = 0; i < 16; i++) begin popCheck("R10 drain"); if (i == 14) waitDrain(); end
    check(regFile[10'h3FF] == 16'h0, "R3 dropped command never sent", regFile[10'h3FF], 0);

    // R5 underflow
    busW(3'd1, 32'hF);
    busR(3'd3, d); check(d == 32'h0, "R5 empty pop is zero", d, 0);
    busR(3'd1, d); check(d[3] == 1'b1, "R5 underflow flag", d[3:0], 8);
    busW(3'd1, 32'h4);
    busR(3'd1, d); check(d[3] == 1'b1, "R5 underflow sticky", d[3:0], 8);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      int k;
      k = 1 + int'($urandom % 14);
      busW(3'd0, {24'h0, 2'b00, 2'($urandom % 3), 4'h1});
      for (int j = 0; j < k; j++) begin
        logic [3:0] op;
        case ($urandom % 3)
          0: op = 4'b0001;
          1: op = 4'b0010;
          default: op = 4'b0000;
        endcase
        sendCmd(mkCmd(op, 10'($urandom % 16), 16'($urandom)), 1);
      end
      waitDrain();
      for (int j = 0; j < k; j++) popCheck("R10 random stream");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule